// File: doc/BRIEF.md
# Tamper Penalty Delay Timer

This block slows down on-line guessing attacks against a short message authentication code. It counts the integrity-check failures reported by a memory authentication engine. When the count reaches a fixed limit, it holds a stall request to the processor pipeline. The stall lasts for a set number of pulses from an independent timebase, so its wall-clock length does not change with the processor clock rate. Software cannot read or write the count, the limit or the remaining delay.

The count and the remaining delay are cleared only by the power-on reset. A soft reset of the surrounding system leaves both untouched. This models state that survives ordinary resets. While the soft reset is held, the block only withdraws its OK indication.

Failures that arrive during a stall are counted toward the next penalty window. Once the limit is reached, further failures are not counted. If the limit is already reached when a window ends, the next window starts at once and the stall request does not drop between the two windows.

Top module: `tamper_delay_timer`

## Requirements
- R1: While `por_n` is low at a clock edge, the failure count and the remaining delay are cleared. After that edge, `stall_o` is 0 and `ok_o` equals `soft_rst_n`.
- R2: Each clock edge that samples `fail_i` high adds one to the failure count. A count below `FAIL_LIMIT` never raises `stall_o`.
- R3: When the edge that samples the `FAIL_LIMIT`-th counted failure comes while no stall is active, `stall_o` is 1 right after that edge.
- R4: A window lasts exactly `DELAY_TICKS` edges that sample `tick_i` high, counted from the edge after the one that started the window. `stall_o` falls right after the last of those edges. A tick sampled on the starting edge does not count.
- R5: The failure count returns to zero when a window starts. Failures sampled during a stall count toward the next window.
- R6: The failure count saturates at `FAIL_LIMIT`. Further failures are dropped, and the count does not wrap.
- R7: If the count is at `FAIL_LIMIT` when a window's last tick is sampled, a new full window starts on that same edge, and `stall_o` stays 1 with no gap.
- R8: A low `soft_rst_n` changes neither the failure count nor the remaining delay.
- R9: `ok_o` is 1 exactly when `stall_o` is 0 and `soft_rst_n` is 1.
- R10: A `tick_i` pulse while no stall is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; the only input that clears state |
| soft_rst_n | input | 1 | System soft reset, active low; withdraws `ok_o` only |
| fail_i | input | 1 | One-cycle pulse per integrity-check failure |
| tick_i | input | 1 | One-cycle pulse from the free-running timebase |
| stall_o | output | 1 | Stall request to the processor pipeline |
| ok_o | output | 1 | Pipeline may continue |

## Verification
The bench sends bursts of failures during a stall, so that a counter that wraps instead of saturating would fail to start the next window when it should. It also checks the seam between two back-to-back windows: a design that re-arms one cycle late would drop `stall_o` for a single cycle.

A tick sampled on the same edge as the final failure has to be ignored. A design that counts it ends the stall one tick early.

Soft reset is asserted in the middle of a window and in the middle of a count. A design that cleared state on soft reset would release the stall early or miss the window that the pending failures should start.

// File: rtl/tdt_pkg.sv
// Package: shared helpers for the tamper delay timer.
// Assumes: callers pass a positive maximum value.
package tdt_pkg;

    // Number of bits needed to hold values from 0 up to maxval.
    function automatic int val_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/tdt_fail_counter.sv
// Module: tdt_fail_counter
// Counts integrity failures, saturating at LIMIT. It asserts fire_o when the
// limit is (or already was) reached and the timer is ready for a new window.
// The count goes back to zero on the edge that fires.
// Assumes: LIMIT >= 1 and arm_i comes from the delay timer. Only por_n clears state.
module tdt_fail_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic por_n,
    input  logic fail_i,
    input  logic arm_i,
    output logic fire_o
);
    import tdt_pkg::*;

    localparam int CW = val_width(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;

    // Next count with this cycle's failure added, held at the limit.
    always_comb begin
        cnt_inc = cnt;
        if (fail_i && (cnt != LIM)) cnt_inc = cnt + CW'(1);
    end

    // Start a window when the limit is reached and the timer is ready.
    always_comb fire_o = arm_i && (cnt_inc == LIM);

    // Count register: cleared by power-on reset or on a window start.
    always_ff @(posedge clk) begin
        if (!por_n)      cnt <= '0;
        else if (fire_o) cnt <= '0;
        else             cnt <= cnt_inc;
    end

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= LIM);
    a_r5_fire_clears: assert property (@(posedge clk) disable iff (!por_n)
        fire_o |=> (cnt == '0));
    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (!fail_i && !fire_o) |=> $stable(cnt));

endmodule

// File: rtl/tdt_delay_timer.sv
// Module: tdt_delay_timer
// Counts down the stall window in timebase ticks. It reports when it can accept
// a new window, either idle or on the final tick of the current one.
// Assumes: TICKS >= 1 and tick_i is a one-cycle pulse. Only por_n clears state.
module tdt_delay_timer #(
    parameter int TICKS = 60
) (
    input  logic clk,
    input  logic por_n,
    input  logic load_i,
    input  logic tick_i,
    output logic arm_o,
    output logic stall_o
);
    import tdt_pkg::*;

    localparam int DW = val_width(TICKS);
    localparam logic [DW-1:0] FULL = DW'(TICKS);

    logic [DW-1:0] rem;

    // Ready for a window: idle, or this tick ends the current one.
    always_comb arm_o = (rem == '0) || ((rem == DW'(1)) && tick_i);

    // Stall while any delay remains.
    always_comb stall_o = (rem != '0);

    // Remaining delay: loaded on a window start, decremented per tick.
    always_ff @(posedge clk) begin
        if (!por_n)                     rem <= '0;
        else if (load_i)                rem <= FULL;
        else if (tick_i && rem != '0)   rem <= rem - DW'(1);
    end

    a_r4_full_load: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (rem == FULL));
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!por_n)
        (!tick_i && !load_i) |=> $stable(rem));
    a_r10_idle_tick: assert property (@(posedge clk) disable iff (!por_n)
        ((rem == '0) && !load_i) |=> (rem == '0));

endmodule

// File: rtl/tamper_delay_timer.sv
// Module: tamper_delay_timer (top)
// Failure-count penalty timer. After every FAIL_LIMIT integrity failures it
// raises a stall request for DELAY_TICKS timebase pulses.
// Assumes: por_n is the power-on reset (synchronous, active low), and soft_rst_n
// only gates ok_o. There is no software access.
module tamper_delay_timer #(
    parameter int FAIL_LIMIT  = 10,
    parameter int DELAY_TICKS = 60
) (
    input  logic clk,
    input  logic por_n,
    input  logic soft_rst_n,
    input  logic fail_i,
    input  logic tick_i,
    output logic stall_o,
    output logic ok_o
);
    logic fire;
    logic arm;

    // Failure counter that starts penalty windows.
    tdt_fail_counter #(.LIMIT(FAIL_LIMIT)) u_cnt (
        .clk    (clk),
        .por_n  (por_n),
        .fail_i (fail_i),
        .arm_i  (arm),
        .fire_o (fire)
    );

    // Timebase-driven countdown of the stall window.
    tdt_delay_timer #(.TICKS(DELAY_TICKS)) u_tmr (
        .clk     (clk),
        .por_n   (por_n),
        .load_i  (fire),
        .tick_i  (tick_i),
        .arm_o   (arm),
        .stall_o (stall_o)
    );

    // OK only while not stalling and out of soft reset.
    always_comb ok_o = !stall_o && soft_rst_n;

    a_r9_ok_excludes_stall: assert property (@(posedge clk) disable iff (!por_n)
        stall_o |-> !ok_o);
    a_r8_soft_drops_ok: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst_n |-> !ok_o);
    a_r7_no_gap: assert property (@(posedge clk) disable iff (!por_n)
        (stall_o && fire) |=> stall_o);
    a_r3_fire_stalls: assert property (@(posedge clk) disable iff (!por_n)
        fire |=> stall_o);

endmodule

// File: tb/tamper_delay_timer_tb.sv
module tamper_delay_timer_tb;
    localparam int LIM = 4;
    localparam int DLY = 3;

    logic clk = 0;
    logic por_n = 0;
    logic soft_rst_n = 1;
    logic fail_i = 0;
    logic tick_i = 0;
    logic stall_o, ok_o;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tamper_delay_timer #(.FAIL_LIMIT(LIM), .DELAY_TICKS(DLY)) u_dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .fail_i(fail_i), .tick_i(tick_i), .stall_o(stall_o), .ok_o(ok_o)
    );

    // Vector: {fail, tick, soft_rst_n, expected stall, expected ok}
    localparam int NV = 16;
    localparam logic [4:0] VEC [NV] = '{
        5'b10101, // R2 one failure
        5'b10101, // R2 two
        5'b01101, // R10 tick while idle
        5'b10101, // R2 three
        5'b10110, // R3 fourth failure: stall
        5'b01110, // R4 tick 1
        5'b10110, // R5 failure during stall counted
        5'b01110, // R4 tick 2
        5'b01101, // R4 tick 3 ends the window
        5'b10101, // R5 count is now 2
        5'b10000, // R8 soft reset held, count 3
        5'b00000, // R9 ok low in soft reset
        5'b10110, // R8 count kept: fourth starts a window
        5'b01010, // R8 soft reset during stall, tick 1
        5'b01110, // R4 tick 2
        5'b01101  // R4 tick 3 ends the window
    };

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge and sample just after the next rising edge.
    task automatic cyc(input logic f, input logic t, input logic s);
        @(negedge clk);
        fail_i = f; tick_i = t; soft_rst_n = s;
        @(posedge clk);
        #1;
    endtask

    task automatic por_pulse();
        @(negedge clk);
        por_n = 0; fail_i = 0; tick_i = 0; soft_rst_n = 1;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk); por_n = 1;
    endtask

    initial begin
        #1_000_000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        por_pulse();
        chk("R1 stall after reset", stall_o, 1'b0);
        chk("R1 ok after reset", ok_o, 1'b1);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][4], VEC[i][3], VEC[i][2]);
            chk($sformatf("R2-table stall v%0d", i), stall_o, VEC[i][1]);
            chk($sformatf("R9 table ok v%0d", i), ok_o, VEC[i][0]);
        end

        // R6 / R7: saturation during a stall, then back-to-back windows.
        for (int i = 0; i < LIM; i++) cyc(1, 0, 1);
        chk("R3 window start", stall_o, 1'b1);
        for (int i = 0; i < 6; i++) cyc(1, 0, 1);
        cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 1);
        chk("R7 no gap between windows", stall_o, 1'b1);
        cyc(0, 0, 1);
        chk("R7 still stalling", stall_o, 1'b1);
        cyc(0, 1, 1); cyc(0, 1, 1);
        chk("R7 second window tick 2", stall_o, 1'b1);
        cyc(0, 1, 1);
        chk("R4 second window ends", stall_o, 1'b0);
        for (int i = 0; i < LIM - 1; i++) cyc(1, 0, 1);
        chk("R6 excess failures dropped", stall_o, 1'b0);
        cyc(1, 0, 1);
        chk("R6 fresh window after limit", stall_o, 1'b1);
        cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 1);
        chk("R4 window over", stall_o, 1'b0);

        // R4: a tick on the starting edge does not count.
        for (int i = 0; i < LIM - 1; i++) cyc(1, 0, 1);
        cyc(1, 1, 1);
        chk("R3 stall with tick", stall_o, 1'b1);
        cyc(0, 1, 1); cyc(0, 1, 1);
        chk("R4 start tick ignored", stall_o, 1'b1);
        cyc(0, 1, 1);
        chk("R4 ends after full count", stall_o, 1'b0);

        // R8: a long soft reset mid-window keeps the remaining delay.
        for (int i = 0; i < LIM; i++) cyc(1, 0, 1);
        cyc(0, 1, 1);
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R8 stall kept in soft reset", stall_o, 1'b1);
        chk("R8 ok low in soft reset", ok_o, 1'b0);
        cyc(0, 1, 1);
        chk("R8 remaining delay kept", stall_o, 1'b1);
        cyc(0, 1, 1);
        chk("R8 window ends on schedule", stall_o, 1'b0);
        chk("R9 ok returns", ok_o, 1'b1);

        // R1: power-on reset clears the count and the window.
        for (int i = 0; i < LIM; i++) cyc(1, 0, 1);
        cyc(1, 0, 1); cyc(1, 0, 1);
        por_pulse();
        chk("R1 por clears stall", stall_o, 1'b0);
        for (int i = 0; i < LIM - 1; i++) cyc(1, 0, 1);
        chk("R1 por clears count", stall_o, 1'b0);
        cyc(1, 0, 1);
        chk("R1 count restarts from zero", stall_o, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule